// File: doc/BRIEF.md
# Demand-Actuated Two-Street Signal Controller

This block is a synchronous state machine for a two-street intersection, here called street A and street B. Each street has one car-waiting sensor input and one three-lamp signal head output. The controller keeps green on the street that holds right of way for as long as the other street is empty. When a car waits on the crossing street, the controller shows yellow for one clock cycle and then hands the green over. Every green that follows a handover lasts at least `MIN_GREEN` cycles before the crossing street can take it back.

All timing is counted in clock cycles. The sensors are sampled on the rising edge of the clock. The block has no streaming data path, so every pin is a plain control or status level with no valid/ready handshake. The synchronous reset sends the controller straight to A green, B red.

Top module: `xing_ctrl`

## Requirements
- R1: Each signal head `lamp_a` and `lamp_b` is one-hot with bit 2 = red, bit 1 = yellow and bit 0 = green, so red is 3'b100, yellow is 3'b010 and green is 3'b001.
- R2: At least one of the two streets shows red in every cycle.
- R3: While A shows green and `car_b` is low, A still shows green in the next cycle.
- R4: When A's green has run its minimum and `car_b` is high at a clock edge, A shows yellow for exactly one cycle. In the following cycle A shows red and B shows green.
- R5: When B's green has run its minimum and `car_a` is high at a clock edge, B shows yellow for exactly one cycle. In the following cycle B shows red and A shows green.
- R6: A green that starts after a yellow, or after reset, lasts at least `MIN_GREEN` cycles (default 2), even if the crossing street's sensor is high the whole time.
- R7: A request that is present during the minimum green is acted on at the edge that ends the minimum: yellow appears in the cycle right after the last minimum-green cycle. If the request has gone by then, the green holds.
- R8: Reset is synchronous and active high. One clock edge with `rst` high gives A green and B red from any state, which is well inside six cycles.
- R9: While B shows green and `car_a` is low, B still shows green in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset switch |
| car_a | input | 1 | Car waiting on street A |
| car_b | input | 1 | Car waiting on street B |
| lamp_a | output | 3 | Street A head {red, yellow, green}, one-hot |
| lamp_b | output | 3 | Street B head {red, yellow, green}, one-hot |

## Verification
The bench builds the controller with the default `MIN_GREEN` of 2. With that value a full A-to-B-to-A rotation takes only a handful of cycles, so a short vector table can cover several things:
- a request that arrives during the minimum;
- a request that is withdrawn before the minimum ends;
- two simultaneous requests;
- a reset that lands in the middle of a yellow.

Directed runs then hold each street idle for long stretches and pull reset out of a B green to measure the recovery.

// File: rtl/xing_pkg.sv
package xing_pkg;
  typedef enum logic [2:0] {
    PH_A_MIN  = 3'd0,
    PH_A_HOLD = 3'd1,
    PH_A_YEL  = 3'd2,
    PH_B_MIN  = 3'd3,
    PH_B_HOLD = 3'd4,
    PH_B_YEL  = 3'd5
  } phase_t;

  localparam int LAMP_W = 3;
  localparam logic [LAMP_W-1:0] LAMP_RED = 3'b100;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 3'b001;
endpackage

// File: rtl/xing_min_timer.sv
module xing_min_timer #(
  parameter int MIN_GREEN = 2
) (
  input  logic clk,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(MIN_GREEN + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_GREEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (restart)
      cnt_q <= '0;
    else if (cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
  import xing_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_a,
  input  logic   car_b,
  input  logic   min_done,
  output logic   timer_restart,
  output phase_t phase
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_A_MIN:  if (min_done) ph_d = car_b ? PH_A_YEL : PH_A_HOLD;
      PH_A_HOLD: if (car_b) ph_d = PH_A_YEL;
      PH_A_YEL:  ph_d = PH_B_MIN;
      PH_B_MIN:  if (min_done) ph_d = car_a ? PH_B_YEL : PH_B_HOLD;
      PH_B_HOLD: if (car_a) ph_d = PH_B_YEL;
      PH_B_YEL:  ph_d = PH_A_MIN;
      default:   ph_d = PH_A_MIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_A_MIN;
    else     ph_q <= ph_d;
  end

  // The timer restarts on any edge that leads into a minimum-green phase.
  assign timer_restart = rst || (ph_q == PH_A_YEL) || (ph_q == PH_B_YEL);
  assign phase = ph_q;
endmodule

// File: rtl/xing_lamp_dec.sv
module xing_lamp_dec
  import xing_pkg::*;
#(
  parameter bit SIDE_B = 1'b0
) (
  input  phase_t            phase,
  output logic [LAMP_W-1:0] lamp
);
  logic is_grn, is_yel;

  generate
    if (SIDE_B) begin : g_side_b
      assign is_grn = (phase == PH_B_MIN) || (phase == PH_B_HOLD);
      assign is_yel = (phase == PH_B_YEL);
    end else begin : g_side_a
      assign is_grn = (phase == PH_A_MIN) || (phase == PH_A_HOLD);
      assign is_yel = (phase == PH_A_YEL);
    end
  endgenerate

  always_comb begin
    if (is_grn)      lamp = LAMP_GRN;
    else if (is_yel) lamp = LAMP_YEL;
    else             lamp = LAMP_RED;
  end
endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl
  import xing_pkg::*;
#(
  parameter int MIN_GREEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_a,
  input  logic       car_b,
  output logic [2:0] lamp_a,
  output logic [2:0] lamp_b
);
  localparam int N_SIDES = 2;

  phase_t            phase;
  logic              min_done;
  logic              t_restart;
  logic [LAMP_W-1:0] heads [N_SIDES];

  xing_min_timer #(.MIN_GREEN(MIN_GREEN)) u_timer (
    .clk     (clk),
    .restart (t_restart),
    .expired (min_done)
  );

  xing_phase_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .car_a         (car_a),
    .car_b         (car_b),
    .min_done      (min_done),
    .timer_restart (t_restart),
    .phase         (phase)
  );

  generate
    for (genvar s = 0; s < N_SIDES; s++) begin : g_head
      xing_lamp_dec #(.SIDE_B(s == 1)) u_dec (
        .phase (phase),
        .lamp  (heads[s])
      );
    end
  endgenerate

  assign lamp_a = heads[0];
  assign lamp_b = heads[1];
endmodule

// File: rtl/xing_ctrl_chk.sv
module xing_ctrl_chk #(
  parameter int MIN_GREEN = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       car_a,
  input logic       car_b,
  input logic [2:0] lamp_a,
  input logic [2:0] lamp_b
);
  localparam int RW = $clog2(MIN_GREEN + 1) + 1;
  localparam logic [RW-1:0] SAT  = RW'(MIN_GREEN);
  localparam logic [RW-1:0] NEED = RW'(MIN_GREEN - 1);

  logic [RW-1:0] run_a, run_b;

  // Count the earlier consecutive green cycles of each street, saturating.
  always_ff @(posedge clk) begin
    if (rst || !lamp_a[0])  run_a <= '0;
    else if (run_a != SAT)  run_a <= run_a + 1'b1;
    if (rst || !lamp_b[0])  run_b <= '0;
    else if (run_b != SAT)  run_b <= run_b + 1'b1;
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(lamp_a) == 1 && $countones(lamp_b) == 1);

  assert_no_conflict_R2: assert property (@(posedge clk) disable iff (rst)
    lamp_a[2] || lamp_b[2]);

  assert_a_hold_R3: assert property (@(posedge clk) disable iff (rst)
    lamp_a[0] && !car_b |=> lamp_a[0]);

  assert_a_yellow_R4: assert property (@(posedge clk) disable iff (rst)
    lamp_a[1] |=> lamp_a[2] && lamp_b[0]);

  assert_b_yellow_R5: assert property (@(posedge clk) disable iff (rst)
    lamp_b[1] |=> lamp_b[2] && lamp_a[0]);

  assert_min_green_a_R6: assert property (@(posedge clk) disable iff (rst)
    lamp_a[0] && run_a < NEED |=> lamp_a[0]);

  assert_min_green_b_R6: assert property (@(posedge clk) disable iff (rst)
    lamp_b[0] && run_b < NEED |=> lamp_b[0]);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> lamp_a[0] && lamp_b[2]);

  assert_b_hold_R9: assert property (@(posedge clk) disable iff (rst)
    lamp_b[0] && !car_a |=> lamp_b[0]);
endmodule

bind xing_ctrl xing_ctrl_chk #(.MIN_GREEN(MIN_GREEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .car_a  (car_a),
  .car_b  (car_b),
  .lamp_a (lamp_a),
  .lamp_b (lamp_b)
);

// File: tb/sim_xing_ctrl.sv
`timescale 1ns/1ps
module sim_xing_ctrl;
  localparam logic [2:0] R = 3'b100;
  localparam logic [2:0] Y = 3'b010;
  localparam logic [2:0] G = 3'b001;
  localparam int NV = 23;
  localparam int WATCH = 200000;

  // Each entry: {rst, car_a, car_b, expected lamp_a, expected lamp_b after the edge}
  localparam logic [8:0] VEC [NV] = '{
    {3'b100, G, R},  // 0  reset -> A green (R8)
    {3'b000, G, R},  // 1  minimum green
    {3'b000, G, R},  // 2  hold, idle (R3)
    {3'b000, G, R},  // 3
    {3'b000, G, R},  // 4
    {3'b001, Y, R},  // 5  car on B -> yellow (R4)
    {3'b001, R, G},  // 6  one-cycle yellow, B green (R4)
    {3'b010, R, G},  // 7  request during minimum (R6)
    {3'b010, R, Y},  // 8  acted on at end of minimum (R7, R5)
    {3'b010, G, R},  // 9  A green (R5)
    {3'b001, G, R},  // 10 B request during A minimum (R6)
    {3'b001, Y, R},  // 11 at end of minimum (R7)
    {3'b000, R, G},  // 12
    {3'b000, R, G},  // 13
    {3'b000, R, G},  // 14 B hold idle (R9)
    {3'b000, R, G},  // 15
    {3'b011, R, Y},  // 16 both waiting -> B yields (R5)
    {3'b000, G, R},  // 17
    {3'b001, G, R},  // 18 request during minimum...
    {3'b000, G, R},  // 19 ...withdrawn: hold (R7)
    {3'b000, G, R},  // 20
    {3'b001, Y, R},  // 21
    {3'b101, G, R}   // 22 reset mid-yellow (R8)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_a = 1'b0;
  logic car_b = 1'b0;
  logic [2:0] lamp_a, lamp_b;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xing_ctrl u0 (
    .clk(clk), .rst(rst), .car_a(car_a), .car_b(car_b),
    .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic b);
    @(negedge clk);
    rst = r; car_a = a; car_b = b;
    @(posedge clk);
    #2;
  endtask

  task automatic conflict_check();
    n_run++;
    if (!(lamp_a[2] || lamp_b[2])) begin
      n_fail++;
      $display("FAIL R2: actual a=%b b=%b expected one red", lamp_a, lamp_b);
    end
  endtask

  initial begin
    int waited;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6]);
      check($sformatf("R1/R3-R9 vec %0d lamp_a", i), lamp_a, VEC[i][5:3]);
      check($sformatf("R1/R3-R9 vec %0d lamp_b", i), lamp_b, VEC[i][2:0]);
      conflict_check();
    end

    // R3: a long idle stretch keeps A green
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0, 1'b0);
      check("R3 idle A", lamp_a, G);
      conflict_check();
    end

    // Move to B, then R9: a long idle stretch keeps B green
    waited = 0;
    while (lamp_b !== G && waited < 10) begin
      step(1'b0, 1'b0, 1'b1);
      waited++;
    end
    check("R4 reached B green", lamp_b, G);
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 1'b0, 1'b0);
      check("R9 idle B", lamp_b, G);
      conflict_check();
    end

    // R8: one reset edge from B green, with A requested, restores A green
    step(1'b1, 1'b1, 1'b0);
    check("R8 recover lamp_a", lamp_a, G);
    check("R8 recover lamp_b", lamp_b, R);
    step(1'b0, 1'b0, 1'b1);
    check("R6 post-reset minimum", lamp_a, G);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCH && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule